// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table that sits in ordinary memory. A request is accepted only while the walker is idle. The walker then reads the first-level descriptor at the table base plus four times the top twelve address bits. The low two bits of that descriptor select what happens next. The walk can end in a fault, end in a 1MB section or 16MB supersection mapping, or go on to read one word of a 1KB second-level table. The second-level descriptor then gives a 64KB large page, a 4KB small page or a fault.

The memory side has one read port and allows only one read in flight. The request holds its address until it is accepted, and the data comes back one or more cycles later on a response strobe. The translation side uses valid/ready handshakes. The table base sits in a register that can be written at any time. A walk uses the value that was current when its request was accepted.

Result size codes: 0 = 4KB small page, 1 = 64KB large page, 2 = 1MB section, 3 = 16MB supersection.

Top module: `tw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: The first read of a walk goes to the table base plus 4 × VA[31:20], with the low two address bits zero. The base used is the value held when the request was accepted, so writes to the base during a walk affect only later walks.
- R3: A first-level descriptor with bits [1:0] = 00 ends the walk after one read. The result has `rsp_fault` = 1, `rsp_pa` = 0 and `rsp_size` = 0, and every fault result takes this same form.
- R4: A first-level descriptor with bits [1:0] = 11 ends the walk with a fault after one read.
- R5: A first-level descriptor with bits [1:0] = 10 and bit 18 = 0 ends after one read. It gives size 2 and PA = {desc[31:20], VA[19:0]}.
- R6: A first-level descriptor with bits [1:0] = 10 and bit 18 = 1 ends after one read. It gives size 3 and PA = {desc[31:24], VA[23:0]}.
- R7: A first-level descriptor with bits [1:0] = 01 causes exactly one more read, at {desc[31:10], VA[19:12], 2'b00}.
- R8: A second-level descriptor with bits [1:0] = 00 ends the walk with a fault.
- R9: A second-level descriptor with bits [1:0] = 01 gives size 1 and PA = {desc[31:16], VA[15:0]}.
- R10: A second-level descriptor with bit 1 = 1 gives size 0 and PA = {desc[31:12], VA[11:0]}.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged. No new read is issued until the previous read has returned.
- R12: A result stays valid and unchanged until `rsp_ready` is seen. `req_ready` is high only when neither a walk nor a result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbase_we | input | 1 | Write strobe for the table base register |
| tbase_wdata | input | 32 | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_size | output | 2 | Mapping size code (0 on fault) |
| rsp_fault | output | 1 | Translation fault |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |

## Verification
The hardest case to reach from the ports is a base-register write that lands while a walk is already in flight. Only the captured base should steer that walk, and only the new one the next walk. The bench writes a new base in the cycle right after acceptance. It checks the read address of that walk against the old base and the read addresses of following walks against the new one. Descriptor contents are a hashed function of the address, so a sweep over all 4096 first-level indices and all 256 second-level slots of one table reaches every descriptor type. Memory accept, memory latency and result back-pressure vary pseudo-randomly throughout.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int AW          = 32;
  localparam int L1_IDX_W    = 12;
  localparam int L2_IDX_W    = 8;
  localparam int SECT_SHIFT  = AW - L1_IDX_W;          // 20
  localparam int SMALL_SHIFT = SECT_SHIFT - L2_IDX_W;  // 12
  localparam int SUPER_SHIFT = 24;
  localparam int LARGE_SHIFT = 16;
  localparam int L2TAB_SHIFT = L2_IDX_W + 2;           // 10: 1KB tables
  localparam int SUPER_BIT   = 18;

  localparam logic [1:0] SZ_SMALL = 2'd0;
  localparam logic [1:0] SZ_LARGE = 2'd1;
  localparam logic [1:0] SZ_SECT  = 2'd2;
  localparam logic [1:0] SZ_SUPER = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } walk_state_t;
endpackage

// File: rtl/tw_decode.sv
module tw_decode
  import tw_pkg::*;
(
  input  logic          second,
  input  logic [AW-1:0] desc,
  input  logic [AW-1:0] va,
  output logic          is_fault,
  output logic          is_leaf,
  output logic          is_descend,
  output logic [AW-1:0] leaf_pa,
  output logic [1:0]    leaf_size,
  output logic [AW-1:0] l2_addr
);
  always_comb begin
    is_fault   = 1'b0;
    is_leaf    = 1'b0;
    is_descend = 1'b0;
    leaf_pa    = '0;
    leaf_size  = SZ_SMALL;
    l2_addr    = {desc[AW-1:L2TAB_SHIFT], va[SECT_SHIFT-1:SMALL_SHIFT], 2'b00};
    if (!second) begin
      unique case (desc[1:0])
        2'b01: is_descend = 1'b1;
        2'b10: begin
          is_leaf = 1'b1;
          if (desc[SUPER_BIT]) begin
            leaf_pa   = {desc[AW-1:SUPER_SHIFT], va[SUPER_SHIFT-1:0]};
            leaf_size = SZ_SUPER;
          end else begin
            leaf_pa   = {desc[AW-1:SECT_SHIFT], va[SECT_SHIFT-1:0]};
            leaf_size = SZ_SECT;
          end
        end
        default: is_fault = 1'b1;
      endcase
    end else begin
      unique case (desc[1:0])
        2'b00: is_fault = 1'b1;
        2'b01: begin
          is_leaf   = 1'b1;
          leaf_pa   = {desc[AW-1:LARGE_SHIFT], va[LARGE_SHIFT-1:0]};
          leaf_size = SZ_LARGE;
        end
        default: begin
          is_leaf   = 1'b1;
          leaf_pa   = {desc[AW-1:SMALL_SHIFT], va[SMALL_SHIFT-1:0]};
          leaf_size = SZ_SMALL;
        end
      endcase
    end
  end
endmodule

// File: rtl/tw_fsm.sv
module tw_fsm
  import tw_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        is_fault,
  input  logic        is_leaf,
  input  logic        is_descend,
  input  logic        rsp_ready,
  output walk_state_t state,
  output logic        accept,
  output logic        ld_l2,
  output logic        ld_res
);
  walk_state_t nxt;
  logic        in_wait;

  always_comb begin
    in_wait = (state == ST_L1_WAIT || state == ST_L2_WAIT) && mem_rsp_valid;
    accept  = (state == ST_IDLE) && req_valid;
    ld_l2   = (state == ST_L1_WAIT) && mem_rsp_valid && is_descend;
    ld_res  = in_wait && (is_fault || is_leaf);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:    if (accept) nxt = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready) nxt = ST_L1_WAIT;
      ST_L1_WAIT: if (ld_l2) nxt = ST_L2_REQ;
                  else if (ld_res) nxt = ST_DONE;
      ST_L2_REQ:  if (mem_req_ready) nxt = ST_L2_WAIT;
      ST_L2_WAIT: if (ld_res) nxt = ST_DONE;
      ST_DONE:    if (rsp_ready) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/tw_walker.sv
module tw_walker
  import tw_pkg::*;
#(
  parameter logic [31:0] RESET_BASE = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tbase_we,
  input  logic [31:0] tbase_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_size,
  output logic        rsp_fault,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int PAD_W = AW - L1_IDX_W - 2;

  walk_state_t   state;
  logic          accept, ld_l2, ld_res;
  logic          is_fault, is_leaf, is_descend;
  logic [AW-1:0] leaf_pa, l2_addr;
  logic [1:0]    leaf_size;
  logic [AW-1:0] base_q, va_q, addr_q, pa_q;
  logic [1:0]    size_q;
  logic          fault_q;
  logic [AW-1:0] l1_offset;

  assign l1_offset = {{PAD_W{1'b0}}, req_va[AW-1:SECT_SHIFT], 2'b00};

  tw_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .is_fault(is_fault), .is_leaf(is_leaf), .is_descend(is_descend),
    .rsp_ready(rsp_ready), .state(state), .accept(accept),
    .ld_l2(ld_l2), .ld_res(ld_res)
  );

  tw_decode u_dec (
    .second(state == ST_L2_WAIT), .desc(mem_rsp_data), .va(va_q),
    .is_fault(is_fault), .is_leaf(is_leaf), .is_descend(is_descend),
    .leaf_pa(leaf_pa), .leaf_size(leaf_size), .l2_addr(l2_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) base_q <= RESET_BASE;
    else if (tbase_we) base_q <= tbase_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q   <= '0;
      addr_q <= '0;
    end else if (accept) begin
      va_q   <= req_va;
      addr_q <= base_q + l1_offset;
    end else if (ld_l2) begin
      addr_q <= l2_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q    <= '0;
      size_q  <= SZ_SMALL;
      fault_q <= 1'b0;
    end else if (ld_res) begin
      pa_q    <= is_fault ? '0 : leaf_pa;
      size_q  <= is_fault ? SZ_SMALL : leaf_size;
      fault_q <= is_fault;
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (state == ST_DONE);
  assign rsp_pa        = pa_q;
  assign rsp_size      = size_q;
  assign rsp_fault     = fault_q;
endmodule

// File: rtl/tw_walker_chk.sv
module tw_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_pa,
  input logic [1:0]  rsp_size,
  input logic        rsp_fault,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr
);
  assert_accept_reads_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> mem_req_valid);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_fault_form_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_pa == 32'h0 && rsp_size == 2'd0));

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_pa) && $stable(rsp_size) && $stable(rsp_fault)));

  assert_ready_excl_R12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!rsp_valid && !mem_req_valid));

  assert_single_phase_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_req_valid && rsp_valid));
endmodule

bind tw_walker tw_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
  .rsp_size(rsp_size), .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/tw_walker_tb.sv
module tw_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE_A = 32'h0010_0000;
  localparam logic [31:0] BASE_B = 32'h0030_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbase_we = 1'b0;
  logic [31:0] tbase_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_size;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] base_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_walker #(.RESET_BASE(BASE_A)) u_dut (
    .clk(clk), .rst(rst), .tbase_we(tbase_we), .tbase_wdata(tbase_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
    .rsp_size(rsp_size), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Table contents: a hashed function of the byte address.
  // Addresses with bit 31 set hold second-level words, all others first-level words.
  function automatic logic [31:0] desc_of(input logic [31:0] a);
    logic [31:0] h;
    h = a * 32'h9E37_79B1;
    if (a[31]) begin
      case (a[3:2])
        2'd0: return {h[31:2], 2'b00};
        2'd1: return {h[31:2], 2'b01};
        2'd2: return {h[31:2], 2'b10};
        default: return {h[31:2], 2'b11};
      endcase
    end else begin
      case ((a >> 2) % 5)
        0: return {h[31:2], 2'b00};
        1: return {1'b1, h[30:10], 8'h00, 2'b01};
        2: return (h & 32'hFFF0_0000) | 32'h2;
        3: return (h & 32'hFFF0_0000) | 32'h0004_0002;
        default: return {h[31:2], 2'b11};
      endcase
    end
  endfunction

  task automatic do_walk(input logic [31:0] va, input bit base_swap);
    logic [31:0] l1a, d1, l2a, d2, e_pa;
    logic [1:0]  e_size;
    bit          e_fault, got, pend;
    int          e_reads, nreads, delay, stall;
    string       tag;
    logic [31:0] exp_addr [2];

    l1a = base_cur + {18'h0, va[31:20], 2'b00};
    d1 = desc_of(l1a);
    e_reads = 1; e_pa = 0; e_size = 0; e_fault = 0; l2a = 0;
    case (d1[1:0])
      2'b00: begin e_fault = 1; tag = "R3"; end
      2'b11: begin e_fault = 1; tag = "R4"; end
      2'b10: if (d1[18]) begin e_pa = {d1[31:24], va[23:0]}; e_size = 3; tag = "R6"; end
             else begin e_pa = {d1[31:20], va[19:0]}; e_size = 2; tag = "R5"; end
      default: begin
        e_reads = 2;
        l2a = {d1[31:10], va[19:12], 2'b00};
        d2 = desc_of(l2a);
        if (d2[1:0] == 2'b00) begin e_fault = 1; tag = "R8"; end
        else if (d2[1:0] == 2'b01) begin e_pa = {d2[31:16], va[15:0]}; e_size = 1; tag = "R9"; end
        else begin e_pa = {d2[31:12], va[11:0]}; e_size = 0; tag = "R10"; end
      end
    endcase
    exp_addr[0] = l1a;
    exp_addr[1] = l2a;

    req_valid = 1'b1;
    req_va = va;
    got = 0; pend = 0; delay = 0; nreads = 0;
    for (int k = 0; k < 200 && !got; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      tbase_we = 1'b0;
      if (base_swap && k == 0) begin
        tbase_we = 1'b1;
        tbase_wdata = BASE_B;
      end
      if (rsp_valid) begin
        got = 1;
      end else begin
        chk(!req_ready, "R12 busy", {63'h0, req_ready}, 64'h0);
        if (pend) begin
          if (delay == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = desc_of(mem_req_addr);
            pend = 0;
          end else delay--;
        end else if (mem_req_valid && lfsr[0]) begin
          mem_req_ready = 1'b1;
          if (nreads < 2)
            chk(mem_req_addr == exp_addr[nreads], nreads == 0 ? "R2 l1 addr" : "R7 l2 addr",
                {32'h0, mem_req_addr}, {32'h0, exp_addr[nreads]});
          nreads++;
          pend = 1;
          delay = int'(lfsr[3:2]);
        end
      end
      step_lfsr();
    end
    if (base_swap) base_cur = BASE_B;

    if (!got) begin
      chk(1'b0, "watchdog walk", 64'h0, 64'h1);
      return;
    end
    chk(nreads == e_reads, "R7 read count", 64'(nreads), 64'(e_reads));
    chk(rsp_pa == e_pa && rsp_size == e_size && rsp_fault == e_fault, tag,
        {29'h0, rsp_fault, rsp_size, rsp_pa}, {29'h0, e_fault, e_size, e_pa});
    stall = int'(lfsr[5:4]);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == e_pa && rsp_fault == e_fault, "R12 hold",
          {31'h0, rsp_valid, rsp_pa}, {31'h0, 1'b1, e_pa});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R12 release", {62'h0, req_ready, rsp_valid}, 64'h2);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    base_cur = BASE_A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset",
        {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

    // R3 R4 R5 R6 R7: every first-level index
    for (int i = 0; i < 4096; i++)
      do_walk({i[11:0], 20'(i * 32'h0003_9C5B)}, 1'b0);

    // R8 R9 R10: every slot of one second-level table (index 2 is a table pointer at BASE_A)
    for (int j = 0; j < 256; j++)
      do_walk({12'd2, j[7:0], 12'(j * 7 + 5)}, 1'b0);

    // R2: base rewritten mid-walk, then walks on the new base
    do_walk(32'h0070_1234, 1'b1);
    for (int i = 0; i < 64; i++)
      do_walk({i[11:0], 20'hF0F0F}, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule